// File: doc/BRIEF.md
# Clocked Controller for an Asynchronous Static RAM

This block lets a synchronous system read and write a 32K x 8 asynchronous static RAM. The memory has no clock. It is driven by three active-low strobes (chip select, output enable and write strobe), a 15-bit address and one 8-bit data bus that carries data both ways. The controller generates these from registers. It turns each of the memory's nanosecond minimums into a number of clock cycles to wait. The number is the time divided by the clock period, rounded up, and never less than one. The timing values and the clock period are parameters.

On the host side a request carries a read/write flag, an address and write data. It is accepted in any cycle where the controller reports ready. A read returns its byte with a one-cycle valid strobe. Every access follows the same fixed path: idle, then a setup cycle, then a counted access window, then a hold cycle, then idle again. A write that comes right after a read first passes through a counted turnaround phase. This gives the memory time to release the shared bus before the controller turns on its own drivers.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, chip select, output enable and write strobe are high, the data driver enable is low, `host_ready` is high and `host_rvalid` is low.
- R2: A read drives chip select low, output enable low and write strobe high. A write drives chip select low, write strobe low and output enable high. Output enable and write strobe are never low together.
- R3: The write strobe stays low for exactly WR_CYC consecutive cycles. WR_CYC is the largest of the rounded-up cycle counts for write pulse width, data setup and address-to-end-of-write. During that time the data driver is on, chip select is low, and the address and write data do not change.
- R4: A byte written to an address is returned by a later read of that address. Other addresses are not affected.
- R5: Output enable stays low for exactly RD_CYC cycles. RD_CYC is the largest of the rounded-up counts for read cycle, address access and output-enable access. `host_rvalid` is high for one cycle, RD_CYC+2 cycles after the edge that accepts the read, and `host_rdata` holds the captured byte.
- R6: `host_ready` is high only while the controller is idle. During idle, chip select and write strobe are high and the driver is off. A request made while `host_ready` is low is ignored.
- R7: A write accepted after a read waits TA_CYC extra cycles before its setup cycle. TA_CYC is the rounded-up output-release time. The driver is never turned on fewer than TA_CYC cycles after output enable rises. A write accepted after a write has no such wait.
- R8: Chip select is low for at least one cycle before the write strobe falls. The write strobe is never low while chip select is high.
- R9: The data driver enable is never high while output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request, sampled when ready |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Write data |
| host_ready | output | 1 | Controller idle, request can be accepted |
| host_rvalid | output | 1 | One-cycle read data strobe |
| host_rdata | output | DATA_W | Read data |
| sram_addr | output | ADDR_W | Memory address lines |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_dq_o | output | DATA_W | Data the controller drives onto the bus |
| sram_dq_oe | output | 1 | Bus driver enable, high = drive |
| sram_dq_i | input | DATA_W | Data read back from the bus |

## Verification
Let edge k be the clock edge that accepts a request. For a read, `host_rvalid` is due RD_CYC+2 cycles after edge k. For a write, `host_ready` returns WR_CYC+3 cycles after edge k. When the write follows a read, TA_CYC more cycles are added. The bench computes these counts from the timing parameters using its own rounding function. It counts falling edges from the accepting edge and checks each result at exactly that count. A monitor samples the memory strobes on every falling edge. It measures the width of the write-strobe and output-enable windows, checks for bus contention, and holds the memory model's contents.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_SETUP,
    ST_ACCESS,
    ST_HOLD
  } state_e;

  // Cycles covering a nanosecond minimum: round up, at least one.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int CW     = 3,
  parameter int WR_CYC = 3,
  parameter int RD_CYC = 4,
  parameter int TA_CYC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          wr,
  input  logic          timer_done,
  output state_e        state_q,
  output state_e        state_d,
  output logic          op_wr_d,
  output logic          accept,
  output logic          capture,
  output logic          timer_load,
  output logic [CW-1:0] timer_val
);

  logic op_wr_q;
  logic rd_recent_q;

  always_comb begin
    state_d    = state_q;
    op_wr_d    = op_wr_q;
    timer_load = 1'b0;
    timer_val  = '0;
    case (state_q)
      ST_IDLE: begin
        if (req) begin
          op_wr_d = wr;
          if (wr && rd_recent_q) begin
            state_d    = ST_TURN;
            timer_load = 1'b1;
            timer_val  = CW'(TA_CYC - 1);
          end else begin
            state_d = ST_SETUP;
          end
        end
      end
      ST_TURN: begin
        if (timer_done) state_d = ST_SETUP;
      end
      ST_SETUP: begin
        state_d    = ST_ACCESS;
        timer_load = 1'b1;
        timer_val  = op_wr_q ? CW'(WR_CYC - 1) : CW'(RD_CYC - 1);
      end
      ST_ACCESS: begin
        if (timer_done) state_d = ST_HOLD;
      end
      ST_HOLD: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  assign accept  = (state_q == ST_IDLE) && req;
  assign capture = (state_q == ST_ACCESS) && timer_done && !op_wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      op_wr_q     <= 1'b0;
      rd_recent_q <= 1'b0;
    end else begin
      state_q <= state_d;
      op_wr_q <= op_wr_d;
      if (state_q == ST_HOLD) begin
        rd_recent_q <= !op_wr_q;
      end else if (state_q == ST_TURN) begin
        rd_recent_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sram_ctrl_io.sv
module sram_ctrl_io
  import sram_ctrl_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  state_e        state_d,
  input  logic          op_wr_d,
  input  logic          accept,
  input  logic          capture,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_wdata,
  input  logic [DW-1:0] pin_dq_i,
  output logic [AW-1:0] pin_addr,
  output logic          pin_ce_n,
  output logic          pin_oe_n,
  output logic          pin_we_n,
  output logic [DW-1:0] pin_dq_o,
  output logic          pin_dq_oe,
  output logic          rvalid,
  output logic [DW-1:0] rdata
);

  logic sel_d;
  logic acc_d;
  logic drv_d;

  always_comb begin
    sel_d = (state_d == ST_SETUP) || (state_d == ST_ACCESS);
    acc_d = (state_d == ST_ACCESS);
    drv_d = op_wr_d && (sel_d || (state_d == ST_HOLD));
  end

  // Every memory-facing signal leaves a flop.
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_addr  <= '0;
      pin_ce_n  <= 1'b1;
      pin_oe_n  <= 1'b1;
      pin_we_n  <= 1'b1;
      pin_dq_o  <= '0;
      pin_dq_oe <= 1'b0;
      rvalid    <= 1'b0;
      rdata     <= '0;
    end else begin
      pin_ce_n  <= !sel_d;
      pin_oe_n  <= !(acc_d && !op_wr_d);
      pin_we_n  <= !(acc_d && op_wr_d);
      pin_dq_oe <= drv_d;
      rvalid    <= capture;
      if (accept) begin
        pin_addr <= in_addr;
        pin_dq_o <= in_wdata;
      end
      if (capture) begin
        rdata <= pin_dq_i;
      end
    end
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 10,
  parameter int T_WP_NS = 12,
  parameter int T_DW_NS = 7,
  parameter int T_AW_NS = 12,
  parameter int T_RC_NS = 15,
  parameter int T_AA_NS = 15,
  parameter int T_OE_NS = 8,
  parameter int T_HZ_NS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ready,
  output logic              host_rvalid,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i
);

  localparam int WR_CYC = max_of(ns_to_cyc(T_WP_NS, CLK_NS),
                          max_of(ns_to_cyc(T_DW_NS, CLK_NS), ns_to_cyc(T_AW_NS, CLK_NS)));
  localparam int RD_CYC = max_of(ns_to_cyc(T_RC_NS, CLK_NS),
                          max_of(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS)));
  localparam int TA_CYC = ns_to_cyc(T_HZ_NS, CLK_NS);
  localparam int CW     = $clog2(max_of(WR_CYC, max_of(RD_CYC, TA_CYC)) + 1);

  state_e        state_q;
  state_e        state_d;
  logic          op_wr_d;
  logic          accept;
  logic          capture;
  logic          timer_load;
  logic          timer_done;
  logic [CW-1:0] timer_val;

  sram_ctrl_seq #(
    .CW(CW), .WR_CYC(WR_CYC), .RD_CYC(RD_CYC), .TA_CYC(TA_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .req(host_req), .wr(host_wr),
    .timer_done(timer_done), .state_q(state_q), .state_d(state_d),
    .op_wr_d(op_wr_d), .accept(accept), .capture(capture),
    .timer_load(timer_load), .timer_val(timer_val)
  );

  sram_ctrl_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .load(timer_load), .load_val(timer_val),
    .done(timer_done)
  );

  sram_ctrl_io #(.AW(ADDR_W), .DW(DATA_W)) u_io (
    .clk(clk), .rst(rst), .state_d(state_d), .op_wr_d(op_wr_d),
    .accept(accept), .capture(capture), .in_addr(host_addr),
    .in_wdata(host_wdata), .pin_dq_i(sram_dq_i), .pin_addr(sram_addr),
    .pin_ce_n(sram_ce_n), .pin_oe_n(sram_oe_n), .pin_we_n(sram_we_n),
    .pin_dq_o(sram_dq_o), .pin_dq_oe(sram_dq_oe), .rvalid(host_rvalid),
    .rdata(host_rdata)
  );

  assign host_ready = (state_q == ST_IDLE);

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int AW     = 15,
  parameter int DW     = 8,
  parameter int TA_CYC = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          ready,
  input logic          rvalid,
  input logic          ce_n,
  input logic          oe_n,
  input logic          we_n,
  input logic          dq_oe,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] dq_o
);

  logic [7:0] since_oe;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_oe <= 8'hFF;
    end else if (!oe_n) begin
      since_oe <= 8'd0;
    end else if (since_oe != 8'hFF) begin
      since_oe <= since_oe + 8'd1;
    end
  end

  p_oe_we_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(!oe_n && !we_n));

  p_addr_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && $past(!ce_n)) |-> $stable(addr));

  p_wdata_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (!we_n && $past(!we_n)) |-> ($stable(dq_o) && dq_oe));

  p_strobe_single_r5: assert property (@(posedge clk) disable iff (rst)
    rvalid |=> !rvalid);

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    ready |-> (ce_n && we_n && !dq_oe));

  p_release_gap_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe) |-> (32'(since_oe) >= TA_CYC));

  p_we_in_ce_r8: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> !ce_n);

  p_ce_before_we_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(we_n) |-> $past(!ce_n));

  p_no_contention_r9: assert property (@(posedge clk) disable iff (rst)
    !(dq_oe && !oe_n));

endmodule

bind sram_ctrl sram_ctrl_chk #(
  .AW(ADDR_W), .DW(DATA_W), .TA_CYC(TA_CYC)
) u_chk (
  .clk(clk), .rst(rst), .ready(host_ready), .rvalid(host_rvalid),
  .ce_n(sram_ce_n), .oe_n(sram_oe_n), .we_n(sram_we_n),
  .dq_oe(sram_dq_oe), .addr(sram_addr), .dq_o(sram_dq_o)
);

// File: tb/sram_ctrl_test.sv
module sram_ctrl_test;

  localparam int CLK = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0;
  logic        host_wr = 1'b0;
  logic [14:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_ready, host_rvalid;
  logic [7:0]  host_rdata;
  logic [14:0] sram_addr;
  logic        sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [7:0]  sram_dq_o;
  logic [7:0]  sram_dq_i = 8'hxx;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int e_wr, e_rd, e_ta;
  int we_cnt = 0;
  int oe_cnt = 0;
  bit last_rd = 0;
  logic [7:0] smem [int];
  logic [7:0] refm [int];

  always #(CLK/2) clk = ~clk;

  sram_ctrl #(.CLK_NS(CLK)) uut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
    .host_rvalid(host_rvalid), .host_rdata(host_rdata), .sram_addr(sram_addr),
    .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
  );

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK - 1) / CLK;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Memory model and strobe monitor, all on the falling edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (!sram_we_n) begin
        we_cnt++;
        chk(sram_dq_oe && !sram_ce_n, "R3", {sram_dq_oe, sram_ce_n}, 2);
        smem[int'(sram_addr)] = sram_dq_o;
      end else if (we_cnt != 0) begin
        chk(we_cnt == e_wr, "R3", we_cnt, e_wr);
        we_cnt = 0;
      end
      if (!sram_oe_n) begin
        oe_cnt++;
        chk(!sram_ce_n && sram_we_n, "R2", {sram_ce_n, sram_we_n}, 1);
      end else if (oe_cnt != 0) begin
        chk(oe_cnt == e_rd, "R5", oe_cnt, e_rd);
        oe_cnt = 0;
      end
      if (sram_dq_oe && !sram_oe_n) chk(0, "R9", 1, 0);
    end
    if (!sram_ce_n && !sram_oe_n && sram_we_n)
      sram_dq_i <= smem.exists(int'(sram_addr)) ? smem[int'(sram_addr)] : 8'h00;
    else
      sram_dq_i <= 8'hxx;
  end

  // Called at a falling edge. inject: pulse a stray request while busy (R6).
  task automatic do_op(input bit wr, input logic [14:0] a, input logic [7:0] d,
                       input bit inject);
    int lat;
    int exp;
    logic [7:0] want;
    while (!host_ready) @(negedge clk);
    host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0;
    lat = 1;
    if (wr) begin
      exp = e_wr + 3 + (last_rd ? e_ta : 0);
      while (!host_ready && lat < 40) begin
        if (inject && lat == 2) begin
          host_req = 1'b1; host_wr = 1'b1; host_addr = a ^ 15'h0001; host_wdata = 8'hEE;
        end else begin
          host_req = 1'b0;
        end
        @(negedge clk);
        lat++;
      end
      host_req = 1'b0;
      chk(lat == exp, last_rd ? "R7" : "R3", lat, exp);
      refm[int'(a)] = d;
      last_rd = 0;
    end else begin
      exp = e_rd + 2;
      want = refm.exists(int'(a)) ? refm[int'(a)] : 8'h00;
      while (!host_rvalid && lat < 40) begin
        chk(!host_ready, "R6", host_ready, 0);
        @(negedge clk);
        lat++;
      end
      chk(lat == exp, "R5", lat, exp);
      chk(host_rdata === want, "R4", host_rdata, want);
      @(negedge clk);
      chk(!host_rvalid && host_ready, "R5", {host_rvalid, host_ready}, 1);
      last_rd = 1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    e_wr = mx(cyc(12), mx(cyc(7), cyc(12)));
    e_rd = mx(cyc(15), mx(cyc(15), cyc(8)));
    e_ta = cyc(8);
    repeat (3) @(negedge clk);
    // R1: strobes idle during reset
    chk(sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe, "R1",
        {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe}, 4'b1110);
    rst = 1'b0;
    @(negedge clk);
    chk(host_ready && !host_rvalid && sram_ce_n && sram_oe_n && sram_we_n,
        "R1", {host_ready, host_rvalid}, 2'b10);

    // Directed corners: extreme addresses and data
    do_op(1, 15'h0000, 8'h00, 0);
    do_op(1, 15'h7FFF, 8'hFF, 0);
    do_op(0, 15'h7FFF, 8'h00, 0);
    do_op(0, 15'h0000, 8'h00, 0);
    // Write right after a read: turnaround (R7)
    do_op(1, 15'h1235, 8'h11, 0);
    // Write-after-write: no turnaround, stray request ignored (R6)
    do_op(1, 15'h1234, 8'h5A, 1);
    do_op(0, 15'h1235, 8'h00, 0);
    do_op(0, 15'h1234, 8'h00, 0);
    chk(refm[int'(15'h1235)] == 8'h11, "R6", refm[int'(15'h1235)], 8'h11);

    // Random mix over a small address pool
    for (int i = 0; i < 120; i++) begin
      bit w;
      logic [14:0] a;
      w = $urandom % 2;
      a = 15'h0100 + 15'($urandom % 12);
      do_op(w, a, 8'($urandom), 0);
    end
    // Read back the whole pool (R4)
    for (int i = 0; i < 12; i++) do_op(0, 15'h0100 + 15'(i), 8'h00, 0);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule